// File: doc/BRIEF.md
# Auto-Incrementing Indirect Memory Window

This block lets a narrow host register interface reach a larger internal word memory and a separate peripheral register space through a handful of window registers. For memory, the host loads a byte address into a read pointer or a write pointer, then accesses the matching data register. Every data access moves that pointer on by one 32-bit word, so a buffer is streamed without reloading the address. Read and write pointers are independent.

For the peripheral space, the host loads a command word holding a 16-bit register offset and a transfer size, then accesses a data register. The block runs one request/acknowledge transfer on a simple peripheral bus with byte enables taken from the size. Peripheral reads return only the requested low-order bytes.

The host issues one request at a time and waits for the single-cycle `host_ready` pulse before issuing the next. The memory is synchronous, so a memory data read stalls one extra cycle.

Top module: `iaw_window`

## Requirements
- R1: After synchronous reset, `host_ready`, `per_req` and `mem_err` are 0 and both memory pointers read back as 0.
- R2: Host register map (selected by `host_addr`, bits 1:0 must be 0): 0x00 memory read pointer, 0x04 memory write pointer, 0x08 memory write data, 0x0C memory read data, 0x10 peripheral write command, 0x14 peripheral read command, 0x18 peripheral write data, 0x1C peripheral read data. A pointer write loads all 32 bits; reading a pointer returns its current value including every increment.
- R3: A write to 0x08 stores the data at word `wptr[AW-1:2]` (AW = log2(MEM_WORDS)+2) and then adds 4 to the write pointer.
- R4: A read of 0x0C returns the word at the read pointer and adds 4 to the read pointer; `host_ready` rises two cycles after the request cycle, never one.
- R5: Pointer increments wrap bits AW-1:0 modulo the memory size in bytes while bits 31:AW stay unchanged.
- R6: A pointer with any bit 31:AW set is out of range: a data read returns 0, a data write leaves memory unchanged, and `mem_err` goes to 1 and stays 1 until reset. The pointer still advances.
- R7: Peripheral command word: bits 15:0 are the register offset driven on `per_addr`, bits 25:24 hold byte count minus one. `per_be` is 0001, 0011, 0111 or 1111 for sizes 0 to 3. `per_req` and its fields hold steady until `per_ack`. A write drives `per_we`=1 with the host data.
- R8: A peripheral read returns `per_rdata` with the bytes outside `per_be` forced to zero.
- R9: Peripheral command registers do not advance on data accesses and read back the last value written.
- R10: Every accepted request yields exactly one single-cycle `host_ready` pulse; register loads and readbacks complete one cycle after the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | One-cycle host request |
| host_we | input | 1 | 1 = register write, 0 = register read |
| host_addr | input | 6 | Byte offset of the window register |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid with host_ready |
| host_ready | output | 1 | Completion pulse |
| per_req | output | 1 | Peripheral transfer request, held until ack |
| per_we | output | 1 | Peripheral write when 1 |
| per_addr | output | 16 | Peripheral register offset |
| per_be | output | 4 | Peripheral byte enables |
| per_wdata | output | 32 | Peripheral write data |
| per_rdata | input | 32 | Peripheral read data, valid with per_ack |
| per_ack | input | 1 | Peripheral transfer acknowledge |
| mem_err | output | 1 | Sticky out-of-range memory access flag |

## Verification
The hardest states to reach are a pointer crossing the top of the memory and a pointer whose upper bits lie outside the implemented range, because streaming from zero would take hundreds of accesses to get there. The bench loads pointers directly to the last word and to an address with bit 16 set, then streams across the boundary. It confirms the wrap by reading the pointer back and by reading the word that landed at address zero. It also reads address zero after an out-of-range write to show that the write was dropped.

// File: rtl/iaw_pkg.sv
package iaw_pkg;
  typedef enum logic [2:0] {
    REG_MEM_RPTR = 3'd0,
    REG_MEM_WPTR = 3'd1,
    REG_MEM_WDAT = 3'd2,
    REG_MEM_RDAT = 3'd3,
    REG_PER_WCMD = 3'd4,
    REG_PER_RCMD = 3'd5,
    REG_PER_WDAT = 3'd6,
    REG_PER_RDAT = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_MEM_RD = 2'd1,
    ST_PER    = 2'd2
  } win_state_e;

  // size field = byte count minus one, enables fill from the low byte up
  function automatic logic [3:0] size_to_be(input logic [1:0] sz);
    case (sz)
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      2'd2:    return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/iaw_sram.sv
module iaw_sram #(
  parameter int WORDS = 256,
  parameter int DW    = 32,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/iaw_ptr.sv
module iaw_ptr #(
  parameter int AW = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic [31:0] load_val,
  input  logic        step,
  output logic [31:0] ptr,
  output logic        in_range
);
  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else if (step) ptr <= {ptr[31:AW], ptr[AW-1:0] + AW'(4)};
  end

  assign in_range = ~|ptr[31:AW];
endmodule

// File: rtl/iaw_per_port.sv
module iaw_per_port
  import iaw_pkg::*;
#(
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_we,
  input  logic [OW-1:0] start_off,
  input  logic [1:0]    start_size,
  input  logic [31:0]   start_wdata,
  output logic          per_req,
  output logic          per_we,
  output logic [OW-1:0] per_addr,
  output logic [3:0]    per_be,
  output logic [31:0]   per_wdata,
  input  logic          per_ack,
  input  logic [31:0]   per_rdata,
  output logic          done,
  output logic [31:0]   rdata
);
  logic [31:0] keep_mask;

  for (genvar b = 0; b < 4; b++) begin : g_mask
    assign keep_mask[8*b +: 8] = {8{per_be[b]}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      per_req   <= 1'b0;
      per_we    <= 1'b0;
      per_addr  <= '0;
      per_be    <= '0;
      per_wdata <= '0;
      done      <= 1'b0;
      rdata     <= '0;
    end else begin
      done <= 1'b0;
      if (start && !per_req) begin
        per_req   <= 1'b1;
        per_we    <= start_we;
        per_addr  <= start_off;
        per_be    <= size_to_be(start_size);
        per_wdata <= start_wdata;
      end else if (per_req && per_ack) begin
        per_req <= 1'b0;
        done    <= 1'b1;
        rdata   <= per_we ? 32'h0 : (per_rdata & keep_mask);
      end
    end
  end
endmodule

// File: rtl/iaw_window.sv
module iaw_window
  import iaw_pkg::*;
#(
  parameter int MEM_WORDS = 256,
  parameter int PER_OW    = 16,
  localparam int IW       = $clog2(MEM_WORDS),
  localparam int AW       = IW + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [5:0]        host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              host_ready,
  output logic              per_req,
  output logic              per_we,
  output logic [PER_OW-1:0] per_addr,
  output logic [3:0]        per_be,
  output logic [31:0]       per_wdata,
  input  logic [31:0]       per_rdata,
  input  logic              per_ack,
  output logic              mem_err
);
  win_state_e  st;
  reg_sel_e    sel;
  logic        accept, mapped, wr, rd;
  logic [1:0]  ld, stp, inr;
  logic [31:0] mptr [2];
  logic [31:0] pwcmd, prcmd, rd_mux, ram_q, per_rd;
  logic        mem_rd_go, per_go, per_done, rd_oor;
  logic [31:0] cmd_sel;

  assign sel    = reg_sel_e'(host_addr[4:2]);
  assign mapped = !host_addr[5] && (host_addr[1:0] == 2'b00);
  assign accept = host_req && (st == ST_IDLE);
  assign wr     = accept && mapped && host_we;
  assign rd     = accept && mapped && !host_we;

  // index 0 = memory read pointer, index 1 = memory write pointer
  assign ld[0]  = wr && (sel == REG_MEM_RPTR);
  assign ld[1]  = wr && (sel == REG_MEM_WPTR);
  assign stp[0] = (st == ST_MEM_RD);
  assign stp[1] = wr && (sel == REG_MEM_WDAT);

  for (genvar g = 0; g < 2; g++) begin : g_ptr
    iaw_ptr #(.AW(AW)) u_ptr (
      .clk      (clk),
      .rst      (rst),
      .load     (ld[g]),
      .load_val (host_wdata),
      .step     (stp[g]),
      .ptr      (mptr[g]),
      .in_range (inr[g])
    );
  end

  assign mem_rd_go = rd && (sel == REG_MEM_RDAT);

  iaw_sram #(.WORDS(MEM_WORDS), .DW(32)) u_sram (
    .clk   (clk),
    .we    (stp[1] && inr[1]),
    .waddr (mptr[1][AW-1:2]),
    .wdata (host_wdata),
    .re    (mem_rd_go),
    .raddr (mptr[0][AW-1:2]),
    .rdata (ram_q)
  );

  assign per_go  = (wr && (sel == REG_PER_WDAT)) || (rd && (sel == REG_PER_RDAT));
  assign cmd_sel = host_we ? pwcmd : prcmd;

  iaw_per_port #(.OW(PER_OW)) u_per (
    .clk         (clk),
    .rst         (rst),
    .start       (per_go),
    .start_we    (host_we),
    .start_off   (cmd_sel[PER_OW-1:0]),
    .start_size  (cmd_sel[25:24]),
    .start_wdata (host_wdata),
    .per_req     (per_req),
    .per_we      (per_we),
    .per_addr    (per_addr),
    .per_be      (per_be),
    .per_wdata   (per_wdata),
    .per_ack     (per_ack),
    .per_rdata   (per_rdata),
    .done        (per_done),
    .rdata       (per_rd)
  );

  always_comb begin
    rd_mux = 32'h0;
    if (!host_we && mapped) begin
      case (sel)
        REG_MEM_RPTR: rd_mux = mptr[0];
        REG_MEM_WPTR: rd_mux = mptr[1];
        REG_PER_WCMD: rd_mux = pwcmd;
        REG_PER_RCMD: rd_mux = prcmd;
        default:      rd_mux = 32'h0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      host_ready <= 1'b0;
      host_rdata <= '0;
      mem_err    <= 1'b0;
      pwcmd      <= '0;
      prcmd      <= '0;
      rd_oor     <= 1'b0;
    end else begin
      host_ready <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            if (mem_rd_go) begin
              st     <= ST_MEM_RD;
              rd_oor <= !inr[0];
            end else if (per_go) begin
              st <= ST_PER;
            end else begin
              host_ready <= 1'b1;
              host_rdata <= rd_mux;
              if (wr && sel == REG_PER_WCMD) pwcmd <= host_wdata;
              if (wr && sel == REG_PER_RCMD) prcmd <= host_wdata;
              if (stp[1] && !inr[1]) mem_err <= 1'b1;
            end
          end
        end
        ST_MEM_RD: begin
          host_ready <= 1'b1;
          host_rdata <= rd_oor ? 32'h0 : ram_q;
          if (rd_oor) mem_err <= 1'b1;
          st <= ST_IDLE;
        end
        ST_PER: begin
          if (per_done) begin
            host_ready <= 1'b1;
            host_rdata <= per_rd;
            st         <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/iaw_window_chk.sv
module iaw_window_chk (
  input logic        clk,
  input logic        rst,
  input logic        host_req,
  input logic        host_we,
  input logic [5:0]  host_addr,
  input logic        host_ready,
  input logic        per_req,
  input logic        per_ack,
  input logic [15:0] per_addr,
  input logic [3:0]  per_be,
  input logic        mem_err
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!host_ready && !per_req && !mem_err));

  assert_read_stall_R4: assert property (@(posedge clk) disable iff (rst)
    (host_req && !host_we && host_addr == 6'h0C && !per_req && !host_ready) |=> !host_ready);

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    mem_err |=> mem_err);

  assert_be_legal_R7: assert property (@(posedge clk) disable iff (rst)
    per_req |-> (per_be == 4'b0001 || per_be == 4'b0011 || per_be == 4'b0111 || per_be == 4'b1111));

  assert_per_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (per_req && !per_ack) |=> (per_req && $stable(per_addr) && $stable(per_be)));

  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    host_ready |=> !host_ready);
endmodule

bind iaw_window iaw_window_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_req   (host_req),
  .host_we    (host_we),
  .host_addr  (host_addr),
  .host_ready (host_ready),
  .per_req    (per_req),
  .per_ack    (per_ack),
  .per_addr   (per_addr),
  .per_be     (per_be),
  .mem_err    (mem_err)
);

// File: tb/iaw_window_tb_top.sv
`timescale 1ns/1ps
module iaw_window_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_ready;
  logic        per_req, per_we;
  logic [15:0] per_addr;
  logic [3:0]  per_be;
  logic [31:0] per_wdata;
  logic [31:0] per_rdata = '0;
  logic        per_ack = 1'b0;
  logic        mem_err;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  iaw_window dut_i (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_ready(host_ready), .per_req(per_req), .per_we(per_we),
    .per_addr(per_addr), .per_be(per_be), .per_wdata(per_wdata),
    .per_rdata(per_rdata), .per_ack(per_ack), .mem_err(mem_err)
  );

  // peripheral register model: 16 words, offset bits 5:2 pick the word
  logic [31:0] pregs [16];
  logic [15:0] last_addr = '0;
  logic [3:0]  last_be = '0;
  logic        last_we = 1'b0;
  initial for (int i = 0; i < 16; i++) pregs[i] = 32'h0;

  always @(posedge clk) begin
    per_ack <= per_req && !per_ack;
    if (per_req && !per_ack) begin
      last_addr <= per_addr;
      last_be   <= per_be;
      last_we   <= per_we;
      per_rdata <= pregs[per_addr[5:2]];
      if (per_we)
        for (int b = 0; b < 4; b++)
          if (per_be[b]) pregs[per_addr[5:2]][8*b +: 8] <= per_wdata[8*b +: 8];
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic host_op(input logic we, input logic [5:0] off, input logic [31:0] wd,
                         output logic [31:0] rd, output int lat);
    int n;
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = off; host_wdata = wd;
    @(negedge clk);
    host_req = 1'b0;
    n = 0;
    while (!host_ready && n < 50) begin
      @(negedge clk);
      n++;
    end
    lat = host_ready ? n : -1;
    rd  = host_rdata;
  endtask

  typedef struct packed {
    logic        rd;
    logic [5:0]  off;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'h04, 32'h0000_0010, 4'd2},  // R2 load write pointer
    '{1'b0, 6'h08, 32'h1111_1111, 4'd3},  // R3
    '{1'b0, 6'h08, 32'h2222_2222, 4'd3},  // R3
    '{1'b0, 6'h08, 32'h3333_3333, 4'd3},  // R3
    '{1'b1, 6'h04, 32'h0000_001C, 4'd2},  // R2 readback after increments
    '{1'b0, 6'h00, 32'h0000_0010, 4'd2},  // R2 load read pointer
    '{1'b1, 6'h0C, 32'h1111_1111, 4'd4},  // R4
    '{1'b1, 6'h0C, 32'h2222_2222, 4'd4},  // R4
    '{1'b1, 6'h0C, 32'h3333_3333, 4'd4},  // R4
    '{1'b1, 6'h00, 32'h0000_001C, 4'd2},  // R2
    '{1'b0, 6'h10, 32'h0300_0008, 4'd7},  // R7 full-word write command
    '{1'b0, 6'h18, 32'hDEAD_BEEF, 4'd7},  // R7
    '{1'b0, 6'h14, 32'h0300_0008, 4'd7},  // R7
    '{1'b1, 6'h1C, 32'hDEAD_BEEF, 4'd7},  // R7
    '{1'b0, 6'h14, 32'h0000_0008, 4'd8},  // R8 one byte
    '{1'b1, 6'h1C, 32'h0000_00EF, 4'd8},  // R8
    '{1'b0, 6'h10, 32'h0100_0008, 4'd7},  // R7 two-byte write
    '{1'b0, 6'h18, 32'h1234_5678, 4'd7},  // R7
    '{1'b0, 6'h14, 32'h0300_0008, 4'd7},  // R7
    '{1'b1, 6'h1C, 32'hDEAD_5678, 4'd7},  // R7 merged by byte enables
    '{1'b0, 6'h14, 32'h0200_0008, 4'd8},  // R8 three bytes
    '{1'b1, 6'h1C, 32'h00AD_5678, 4'd8},  // R8
    '{1'b1, 6'h10, 32'h0100_0008, 4'd9},  // R9 command did not advance
    '{1'b1, 6'h14, 32'h0200_0008, 4'd9}   // R9
  };

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int lat;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 ready", {31'h0, host_ready}, 32'h0);
    check("R1 per_req", {31'h0, per_req}, 32'h0);
    check("R1 mem_err", {31'h0, mem_err}, 32'h0);
    host_op(1'b0, 6'h00, 32'h0, r, lat);
    check("R1 rptr", r, 32'h0);
    check("R10 readback latency", lat, 0);
    host_op(1'b0, 6'h04, 32'h0, r, lat);
    check("R1 wptr", r, 32'h0);

    // table walk (R2 R3 R4 R7 R8 R9)
    for (int i = 0; i < NV; i++) begin
      host_op(!VECS[i].rd, VECS[i].off, VECS[i].data, r, lat);
      if (lat < 0) check($sformatf("R%0d ready timeout", VECS[i].req), 32'hFFFF_FFFF, 32'h0);
      else if (VECS[i].rd) check($sformatf("R%0d vec %0d", VECS[i].req, i), r, VECS[i].data);
    end

    // R10 register write completes next cycle; pulse is one cycle wide
    host_op(1'b1, 6'h00, 32'h0000_0000, r, lat);
    check("R10 write latency", lat, 0);
    @(negedge clk);
    check("R10 single pulse", {31'h0, host_ready}, 32'h0);
    // R4 memory data read stalls exactly one extra cycle
    host_op(1'b0, 6'h0C, 32'h0, r, lat);
    check("R4 read latency", lat, 1);

    // R5 wrap at the top of 1024-byte memory
    host_op(1'b1, 6'h04, 32'h0000_03FC, r, lat);
    host_op(1'b1, 6'h08, 32'hAAAA_0001, r, lat);
    host_op(1'b1, 6'h08, 32'hBBBB_0002, r, lat);
    host_op(1'b0, 6'h04, 32'h0, r, lat);
    check("R5 wptr wrap", r, 32'h0000_0004);
    host_op(1'b1, 6'h00, 32'h0000_03FC, r, lat);
    host_op(1'b0, 6'h0C, 32'h0, r, lat);
    check("R5 top word", r, 32'hAAAA_0001);
    host_op(1'b0, 6'h0C, 32'h0, r, lat);
    check("R5 wrapped word", r, 32'hBBBB_0002);
    host_op(1'b0, 6'h00, 32'h0, r, lat);
    check("R5 rptr wrap", r, 32'h0000_0004);

    // R6 out-of-range accesses
    check("R6 err clear", {31'h0, mem_err}, 32'h0);
    host_op(1'b1, 6'h04, 32'h0001_0000, r, lat);
    host_op(1'b1, 6'h08, 32'hBADB_AD00, r, lat);
    check("R6 err after write", {31'h0, mem_err}, 32'h1);
    host_op(1'b1, 6'h00, 32'h0000_0000, r, lat);
    host_op(1'b0, 6'h0C, 32'h0, r, lat);
    check("R6 write dropped", r, 32'hBBBB_0002);
    host_op(1'b1, 6'h00, 32'h0001_0004, r, lat);
    host_op(1'b0, 6'h0C, 32'h0, r, lat);
    check("R6 read zero", r, 32'h0);
    check("R6 err sticky", {31'h0, mem_err}, 32'h1);
    host_op(1'b0, 6'h00, 32'h0, r, lat);
    check("R6 upper bits kept", r, 32'h0001_0008);

    // R7 bus fields of a two-byte write at offset 0x24
    host_op(1'b1, 6'h10, 32'h0100_0024, r, lat);
    host_op(1'b1, 6'h18, 32'hCAFE_F00D, r, lat);
    check("R7 per_addr", {16'h0, last_addr}, 32'h0000_0024);
    check("R7 per_be", {28'h0, last_be}, 32'h0000_0003);
    check("R7 per_we", {31'h0, last_we}, 32'h1);
    host_op(1'b1, 6'h14, 32'h0300_0024, r, lat);
    host_op(1'b0, 6'h1C, 32'h0, r, lat);
    check("R8 full read", r, 32'h0000_F00D);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule